// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures a digital signal with a saturating binary counter. It has two modes. In frequency mode it counts the rising edges of one of two inputs while a gate is open. The gate lasts a programmable number of 1 ms timebase ticks. In cycle mode it waits for a rising edge of a low-frequency input. It then counts pulses of a chosen reference rate until that input's next rising edge, so the result is one period of the input expressed in reference pulses.

A controller starts a measurement by presenting a write strobe with the start bit set. The same write supplies the gate/reference select and the source select, and the block captures both. A busy flag shows that a run is in progress. The controller reads the result once busy has dropped. The result is trustworthy only when the overflow flag is clear.

Top module: `gated_meas_counter`

## Requirements
- R1: After reset the result is 0, busy is 0 and overflow is 0.
- R2: A cycle with startWr=1 and startBit=1 clears the result and overflow and raises busy from the next cycle. It also captures gateSel and srcSel for the whole run. A write with startBit=0 changes nothing, and neither does any change of gateSel or srcSel outside a start.
- R3: After a start the gate opens on the first tick1ms pulse. In frequency mode the gate stays open for exactly N tick intervals, where N is 1, 4, 16 or 64 for gateSel 0, 1, 2 or 3. The result equals the number of rising edges of the selected input inside that window.
- R4: Source priority is as follows. If srcSel bit 2 is set, the block uses cycle mode on periodIn. Otherwise, if bit 1 is set, it counts freqInB. Otherwise, if bit 0 is set, it counts freqInA. If srcSel is 000, nothing is counted and the result after the gate is 0.
- R5: In cycle mode, after the first tick the block waits for a rising edge of periodIn. It then counts reference pulses until the next rising edge of periodIn. gateSel 0, 1 and 2 pick refPulse bits 0, 1 and 2 (slow, middle and fast rate). gateSel 3 counts every clock cycle.
- R6: Busy stays 1 until the gate closes and is then 0. While idle, the result holds its value.
- R7: If the count would step beyond all ones, overflow is set and the result saturates at all ones. Both stay that way until the next start.
- R8: A start during a run aborts that run and begins a fresh measurement with the newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are synchronous to it |
| rstN | input | 1 | Active-low synchronous reset |
| startWr | input | 1 | Control write strobe |
| startBit | input | 1 | Start bit carried by the write |
| gateSel | input | 2 | Gate length (frequency mode) or reference rate (cycle mode) |
| srcSel | input | 3 | Source select, bit 2 highest priority |
| tick1ms | input | 1 | One-cycle pulse of the 1 ms timebase |
| freqInA | input | 1 | First frequency-mode input |
| freqInB | input | 1 | Second frequency-mode input |
| periodIn | input | 1 | Low-frequency input for cycle mode |
| refPulse | input | 3 | Reference pulse enables, slow to fast |
| result | output | CNT_W (20) | Measured count |
| busy | output | 1 | Measurement in progress |
| overflow | output | 1 | Count exceeded the counter range |

## Verification
Frequency mode is tried with two square waves of different periods across all four gate lengths. These runs separate a wrong gate length, an off-by-one tick window and a swapped input. Source selects that set more than one bit show whether priority is honoured, and the all-zero select shows that no input leaks through. Cycle mode runs every reference choice against one fixed input period, which exposes a wrong reference index or a window that spans the wrong pair of edges. A narrow-counter instance drives the count past its range to show saturation and sticky overflow, and a later start shows that overflow is cleared.

// File: rtl/gmc_pkg.sv
package gmc_pkg;

  localparam int GSEL_W = 2;
  localparam int SRC_W  = 3;
  localparam int REF_N  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT,
    ST_GATE
  } gmcStateT;

  typedef struct packed {
    logic clr;
    logic inc;
  } gmcStrobeT;

endpackage

// File: rtl/gmc_event_sel.sv
module gmc_event_sel
  import gmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              freqInA,
  input  logic              freqInB,
  input  logic              periodIn,
  input  logic [REF_N-1:0]  refPulse,
  input  logic [GSEL_W-1:0] gateSelQ,
  input  logic [SRC_W-1:0]  srcSelQ,
  output logic              cycleMode,
  output logic              periodEdge,
  output logic              countEvent
);

  localparam int SIG_N = 3;

  logic [SIG_N-1:0] sigNow;
  logic [SIG_N-1:0] sigEdge;
  logic [REF_N:0]   refAll;
  logic             refPick;
  logic             freqPick;

  assign sigNow = {periodIn, freqInB, freqInA};

  for (genvar i = 0; i < SIG_N; i++) begin : g_edge
    logic prevQ;
    always_ff @(posedge clk) begin
      if (!rstN) prevQ <= 1'b0;
      else       prevQ <= sigNow[i];
    end
    assign sigEdge[i] = sigNow[i] & ~prevQ;
  end

  // top entry stands for the full-rate clock
  assign refAll  = {1'b1, refPulse};
  assign refPick = refAll[gateSelQ];

  always_comb begin
    if (srcSelQ[1])      freqPick = sigEdge[1];
    else if (srcSelQ[0]) freqPick = sigEdge[0];
    else                 freqPick = 1'b0;
  end

  assign cycleMode  = srcSelQ[2];
  assign periodEdge = sigEdge[2];
  assign countEvent = cycleMode ? refPick : freqPick;

endmodule

// File: rtl/gmc_ctrl.sv
module gmc_ctrl
  import gmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              startBit,
  input  logic [GSEL_W-1:0] gateSel,
  input  logic [SRC_W-1:0]  srcSel,
  input  logic              tick1ms,
  input  logic              cycleMode,
  input  logic              periodEdge,
  input  logic              countEvent,
  output logic [GSEL_W-1:0] gateSelQ,
  output logic [SRC_W-1:0]  srcSelQ,
  output gmcStrobeT         strobes,
  output logic              busy
);

  // longest gate is 4**(2**GSEL_W-1) ticks
  localparam int REM_W = 2 * ((1 << GSEL_W) - 1) + 1;

  gmcStateT         state;
  logic [REM_W-1:0] remain;
  logic [REM_W-1:0] gateLen;
  logic             startNow;

  assign startNow = startWr & startBit;
  assign gateLen  = REM_W'(1) << {gateSelQ, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      remain   <= '0;
      gateSelQ <= '0;
      srcSelQ  <= '0;
    end else if (startNow) begin
      state    <= ST_ARM;
      remain   <= '0;
      gateSelQ <= gateSel;
      srcSelQ  <= srcSel;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_IDLE;
        ST_ARM: begin
          if (tick1ms) begin
            state  <= cycleMode ? ST_WAIT : ST_GATE;
            remain <= gateLen;
          end
        end
        ST_WAIT: begin
          if (periodEdge) state <= ST_GATE;
        end
        ST_GATE: begin
          if (cycleMode) begin
            if (periodEdge) state <= ST_IDLE;
          end else if (tick1ms) begin
            if (remain == REM_W'(1)) state <= ST_IDLE;
            remain <= remain - REM_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobes.clr = startNow;
  assign strobes.inc = !startNow && (state == ST_GATE) && countEvent;
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/gmc_datapath.sv
module gmc_datapath
  import gmc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  gmcStrobeT        strobes,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (strobes.clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (strobes.inc) begin
      if (count == CNT_MAX) ovf <= 1'b1;
      else                  count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/gated_meas_counter.sv
module gated_meas_counter
  import gmc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWr,
  input  logic             startBit,
  input  logic [1:0]       gateSel,
  input  logic [2:0]       srcSel,
  input  logic             tick1ms,
  input  logic             freqInA,
  input  logic             freqInB,
  input  logic             periodIn,
  input  logic [2:0]       refPulse,
  output logic [CNT_W-1:0] result,
  output logic             busy,
  output logic             overflow
);

  logic [GSEL_W-1:0] gateSelQ;
  logic [SRC_W-1:0]  srcSelQ;
  logic              cycleMode;
  logic              periodEdge;
  logic              countEvent;
  gmcStrobeT         strobes;

  gmc_event_sel u_evt (
    .clk        (clk),
    .rstN       (rstN),
    .freqInA    (freqInA),
    .freqInB    (freqInB),
    .periodIn   (periodIn),
    .refPulse   (refPulse),
    .gateSelQ   (gateSelQ),
    .srcSelQ    (srcSelQ),
    .cycleMode  (cycleMode),
    .periodEdge (periodEdge),
    .countEvent (countEvent)
  );

  gmc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startWr    (startWr),
    .startBit   (startBit),
    .gateSel    (gateSel),
    .srcSel     (srcSel),
    .tick1ms    (tick1ms),
    .cycleMode  (cycleMode),
    .periodEdge (periodEdge),
    .countEvent (countEvent),
    .gateSelQ   (gateSelQ),
    .srcSelQ    (srcSelQ),
    .strobes    (strobes),
    .busy       (busy)
  );

  gmc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .count   (result),
    .ovf     (overflow)
  );

endmodule

// File: rtl/gmc_checker.sv
module gmc_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             startWr,
  input logic             startBit,
  input logic [CNT_W-1:0] result,
  input logic             busy,
  input logic             overflow
);

  logic startNow;
  assign startNow = startWr & startBit;

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> (busy && result == '0 && !overflow));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !startNow) |=> overflow);

  p_sat_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (result == {CNT_W{1'b1}}));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startNow) |=> (!busy && $stable(result)));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startNow) |=> (result == $past(result) || result == $past(result) + CNT_W'(1)));

endmodule

bind gated_meas_counter gmc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startWr  (startWr),
  .startBit (startBit),
  .result   (result),
  .busy     (busy),
  .overflow (overflow)
);

// File: tb/gated_meas_counter_tb_top.sv
module gated_meas_counter_tb_top;

  localparam int TICK_CYC = 20;
  localparam int NVEC     = 11;
  localparam int SMALL_W  = 6;

  // {gateSel[15:14], srcSel[13:11], expected[10:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 3'b001, 11'd5},    // R3 1 tick, A period 4
    {2'd1, 3'b001, 11'd20},   // R3 4 ticks
    {2'd2, 3'b010, 11'd160},  // R3 16 ticks, B period 2
    {2'd3, 3'b010, 11'd640},  // R3 64 ticks
    {2'd0, 3'b011, 11'd10},   // R4 B over A
    {2'd1, 3'b000, 11'd0},    // R4 no source
    {2'd0, 3'b100, 11'd2},    // R5 slow ref
    {2'd1, 3'b100, 11'd6},    // R5 middle ref
    {2'd2, 3'b101, 11'd36},   // R5 fast ref, R4 period priority
    {2'd3, 3'b100, 11'd72},   // R5 full clock
    {2'd3, 3'b110, 11'd72}    // R4 period over B
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startWr = 1'b0;
  logic startBit = 1'b0;
  logic [1:0] gateSel = '0;
  logic [2:0] srcSel = '0;
  logic tick1ms = 1'b0;
  logic freqInA = 1'b0;
  logic freqInB = 1'b0;
  logic periodIn = 1'b0;
  logic [2:0] refPulse = '0;
  logic [19:0] result;
  logic busy;
  logic overflow;
  logic [SMALL_W-1:0] resSmall;
  logic busySmall;
  logic ovfSmall;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  gated_meas_counter dut_i (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startBit(startBit),
    .gateSel(gateSel), .srcSel(srcSel), .tick1ms(tick1ms),
    .freqInA(freqInA), .freqInB(freqInB), .periodIn(periodIn),
    .refPulse(refPulse), .result(result), .busy(busy), .overflow(overflow)
  );

  gated_meas_counter #(.CNT_W(SMALL_W)) small_i (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startBit(startBit),
    .gateSel(gateSel), .srcSel(srcSel), .tick1ms(tick1ms),
    .freqInA(freqInA), .freqInB(freqInB), .periodIn(periodIn),
    .refPulse(refPulse), .result(resSmall), .busy(busySmall), .overflow(ovfSmall)
  );

  // stimulus generators, all changing on the falling edge
  always @(negedge clk) begin
    cyc      <= cyc + 1;
    tick1ms  <= ((cyc + 1) % TICK_CYC) == 0;
    freqInA  <= ((cyc + 1) % 4) < 2;
    freqInB  <= ((cyc + 1) % 2) == 0;
    periodIn <= ((cyc + 1) % 72) < 36;
    refPulse <= {((cyc + 1) % 2) == 0, ((cyc + 1) % 12) == 0, ((cyc + 1) % 36) == 0};
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic startMeas(input logic [1:0] gs, input logic [2:0] src, input logic sb);
    @(negedge clk);
    startWr = 1'b1; startBit = sb; gateSel = gs; srcSel = src;
    @(negedge clk);
    startWr = 1'b0; startBit = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R6 busy drops within bound", int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual %0d expected 0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [19:0] held;
    repeat (5) @(negedge clk);
    check("R1 reset result", int'(result), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset overflow", int'(overflow), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 result after release", int'(result), 0);

    for (int i = 0; i < NVEC; i++) begin
      startMeas(VEC[i][15:14], VEC[i][13:11], 1'b1);
      check("R2 busy after start", int'(busy), 1);
      check("R2 result cleared", int'(result), 0);
      waitIdle();
      check($sformatf("R3 R4 R5 vector %0d result", i), int'(result), int'(VEC[i][10:0]));
      check("R7 no overflow", int'(overflow), 0);
    end

    // R2: start=0 write and select changes mid-run have no effect
    startMeas(2'd1, 3'b001, 1'b1);
    repeat (30) @(negedge clk);
    startMeas(2'd3, 3'b010, 1'b0);
    gateSel = 2'd2; srcSel = 3'b100;
    waitIdle();
    check("R2 ignored start=0 write", int'(result), 20);

    // R6: result held while idle
    held = result;
    repeat (200) @(negedge clk);
    check("R6 result held idle", int'(result), int'(held));
    check("R6 busy stays low", int'(busy), 0);

    // R8: restart aborts run
    startMeas(2'd3, 3'b010, 1'b1);
    repeat (57) @(negedge clk);
    startMeas(2'd0, 3'b001, 1'b1);
    check("R8 restart clears result", int'(result), 0);
    waitIdle();
    check("R8 result of new run", int'(result), 5);

    // R7: overflow on narrow instance (160 edges > 63)
    startMeas(2'd2, 3'b010, 1'b1);
    waitIdle();
    check("R7 overflow set", int'(ovfSmall), 1);
    check("R7 saturated result", int'(resSmall), 63);
    check("R3 wide instance same run", int'(result), 160);
    repeat (100) @(negedge clk);
    check("R7 overflow sticky", int'(ovfSmall), 1);
    startMeas(2'd0, 3'b001, 1'b1);
    check("R7 start clears overflow", int'(ovfSmall), 0);
    check("R7 start clears result", int'(resSmall), 0);
    waitIdle();
    check("R7 fresh run after overflow", int'(resSmall), 5);
    check("R7 overflow stays clear", int'(ovfSmall), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule